// File: doc/BRIEF.md
# Twelve-Bit Dual-Copy Bus Driver with Delayed Parity Check

This block drives a 12-bit word onto two identical output copies. A mode input picks the path. In buffer mode the input word flows straight through to both copies with no clock involved. In register mode both copies show a bank of flops loaded on the rising clock edge. An active-low capture enable gates loading of the lower eight flops. The upper four flops load on every edge, whatever the enable says.

Alongside the data path there is a delayed odd-parity check. The word present at one edge is pipelined. The parity bit for that word is presented during the following cycle and compared at the next edge. The pass/fail result goes into an error register, which drives an open-drain style flag: an output-enable that is high while an error is held, plus a data value that is always zero. Input bit `dataIn[10]` is an ordinary data bit. It also acts as an active-low load enable for that error register. The check runs in both modes and is not affected by the capture enable.

Top module: `twin_bus_driver`

## Requirements
- R1: A rising edge with `rstN` low clears all twelve data flops and the parity pipeline, and sets `errOe` to 0 (flag released).
- R2: While `modeBuf` is 1, `outA` equals `dataIn` combinationally.
- R3: While `modeBuf` is 0, `outA` shows the data flops. A rising edge with `capEnN` low loads all twelve bits from `dataIn`.
- R4: A rising edge with `capEnN` high loads `dataIn[11:8]` and leaves flop bits [7:0] unchanged.
- R5: `outB` always carries the same value as `outA`.
- R6: At a rising edge where `dataIn[10]` is 0, `errOe` becomes 1 exactly when the word sampled at the previous edge and the `parIn` value at this edge together hold an even number of ones. Odd parity is the expected case.
- R7: At a rising edge where `dataIn[10]` is 1, `errOe` keeps its value.
- R8: `errVal` is always 0. The wired flag, resolved with a pull-up, is low only while `errOe` is 1.
- R9: The parity pipeline samples all twelve bits of `dataIn` on every edge, in either mode and whatever the level of `capEnN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeBuf | input | 1 | 1 = combinational pass-through, 0 = registered output |
| capEnN | input | 1 | Active-low capture enable for data bits [7:0] |
| dataIn | input | 12 | Input word; bit 10 also enables the error register (active low) |
| parIn | input | 1 | Parity bit for the word sampled at the previous edge |
| outA | output | 12 | First output copy |
| outB | output | 12 | Second output copy |
| errOe | output | 1 | Error flag drive enable (1 = pull low) |
| errVal | output | 1 | Driven value of the error flag, constant 0 |

## Verification
The assertions assume that `rstN`, `capEnN`, `dataIn` and `parIn` are settled at every rising edge. They also assume that reset is held low from time zero through the first edge, so that the parity pipeline never holds unknown values. The bench drives all inputs only at falling edges and keeps reset low for the first edges. After that it mixes random modes, enable levels and words with parity bits that are mostly correct and sometimes inverted. Directed sequences cover mode toggling, enable gating, a single parity fault and holding the flag with bit 10 high.

// File: rtl/twin_bus_pkg.sv
`timescale 1ns/1ps
package twin_bus_pkg;
  // Strobes from control to datapath, valid for the coming rising edge
  typedef struct packed {
    logic clearAll;  // synchronous clear of every flop
    logic loadLow;   // load the gated (lower) data bits
    logic loadHigh;  // load the ungated (upper) data bits
    logic errLoad;   // clock a new parity verdict into the error flop
    logic passThru;  // combinational output path selected
  } strobe_t;
endpackage

// File: rtl/twin_bus_ctrl.sv
`timescale 1ns/1ps
module twin_bus_ctrl
  import twin_bus_pkg::*;
(
  input  logic    rstN,
  input  logic    modeBuf,
  input  logic    capEnN,
  input  logic    errEnN,
  output strobe_t stb
);
  always_comb begin
    stb.clearAll = ~rstN;
    stb.loadLow  = ~capEnN;
    stb.loadHigh = 1'b1;        // upper slice ignores the capture enable
    stb.errLoad  = ~errEnN;
    stb.passThru = modeBuf;
  end
endmodule

// File: rtl/twin_bus_dp.sv
`timescale 1ns/1ps
module twin_bus_dp
  import twin_bus_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int HIGH_BITS = 4
) (
  input  logic             clk,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             parIn,
  output logic [WIDTH-1:0] outA,
  output logic [WIDTH-1:0] outB,
  output logic             errOe,
  output logic             errVal
);
  localparam int LOW_BITS = WIDTH - HIGH_BITS;

  logic [WIDTH-1:0] holdQ, holdD, bitLoad, prevWord, muxOut;
  logic             errQ, parityOk;

  // Per-bit load enable: lower slice gated, upper slice free-running
  for (genvar g = 0; g < WIDTH; g++) begin : gSlice
    if (g < LOW_BITS) begin : gLow
      assign bitLoad[g] = stb.loadLow;
    end else begin : gHigh
      assign bitLoad[g] = stb.loadHigh;
    end
    assign holdD[g] = bitLoad[g] ? dataIn[g] : holdQ[g];
  end

  always_ff @(posedge clk) begin
    if (stb.clearAll) holdQ <= '0;
    else              holdQ <= holdD;
  end

  // Word pipeline for the parity check, independent of mode and enable
  always_ff @(posedge clk) begin
    if (stb.clearAll) prevWord <= '0;
    else              prevWord <= dataIn;
  end

  // Odd parity: word plus parity bit must hold an odd number of ones
  assign parityOk = ^{prevWord, parIn};

  always_ff @(posedge clk) begin
    if (stb.clearAll)     errQ <= 1'b0;
    else if (stb.errLoad) errQ <= ~parityOk;
  end

  assign muxOut = stb.passThru ? dataIn : holdQ;
  assign outA   = muxOut;
  assign outB   = muxOut;
  assign errOe  = errQ;
  assign errVal = 1'b0;

  // ---------------- assertions ----------------
  assert_full_load_R3: assert property (@(posedge clk) disable iff (stb.clearAll)
    (!stb.clearAll && stb.loadLow) |=> holdQ == $past(dataIn));

  assert_low_hold_R4: assert property (@(posedge clk) disable iff (stb.clearAll)
    (!stb.clearAll && !stb.loadLow) |=> holdQ[LOW_BITS-1:0] == $past(holdQ[LOW_BITS-1:0]));

  assert_high_load_R4: assert property (@(posedge clk) disable iff (stb.clearAll)
    !stb.clearAll |=> holdQ[WIDTH-1:LOW_BITS] == $past(dataIn[WIDTH-1:LOW_BITS]));

  assert_err_update_R6: assert property (@(posedge clk) disable iff (stb.clearAll)
    (!stb.clearAll && stb.errLoad) |=> errOe == !$past(^{prevWord, parIn}));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (stb.clearAll)
    (!stb.clearAll && !stb.errLoad) |=> $stable(errOe));

  assert_pipe_all_bits_R9: assert property (@(posedge clk) disable iff (stb.clearAll)
    !stb.clearAll |=> prevWord == $past(dataIn));
endmodule

// File: rtl/twin_bus_driver.sv
`timescale 1ns/1ps
module twin_bus_driver
  import twin_bus_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int HIGH_BITS  = 4,
  parameter int ERR_EN_BIT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeBuf,
  input  logic             capEnN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             parIn,
  output logic [WIDTH-1:0] outA,
  output logic [WIDTH-1:0] outB,
  output logic             errOe,
  output logic             errVal
);
  strobe_t stb;

  twin_bus_ctrl uCtrl (
    .rstN    (rstN),
    .modeBuf (modeBuf),
    .capEnN  (capEnN),
    .errEnN  (dataIn[ERR_EN_BIT]),
    .stb     (stb)
  );

  twin_bus_dp #(.WIDTH(WIDTH), .HIGH_BITS(HIGH_BITS)) uDp (
    .clk    (clk),
    .stb    (stb),
    .dataIn (dataIn),
    .parIn  (parIn),
    .outA   (outA),
    .outB   (outB),
    .errOe  (errOe),
    .errVal (errVal)
  );
endmodule

// File: tb/twin_bus_driver_test.sv
`timescale 1ns/1ps
module twin_bus_driver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeBuf = 1'b0;
  logic        capEnN = 1'b0;
  logic [11:0] dataIn = '0;
  logic        parIn = 1'b0;
  logic [11:0] outA, outB;
  logic        errOe, errVal;
  logic        errWire;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  logic [11:0] expHold = '0;
  logic [11:0] expPrev = '0;
  logic        expErr = 1'b0;

  always #5 clk = ~clk;

  twin_bus_driver uut (
    .clk(clk), .rstN(rstN), .modeBuf(modeBuf), .capEnN(capEnN),
    .dataIn(dataIn), .parIn(parIn), .outA(outA), .outB(outB),
    .errOe(errOe), .errVal(errVal)
  );

  // Open-drain resolution with a pull-up
  assign errWire = errOe ? errVal : 1'b1;

  function automatic logic goodPar(logic [11:0] w);
    return ~(^w);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at a falling edge, check, clock, update model, check again
  task automatic step(bit m, bit cen, logic [11:0] d, bit p, bit rst = 1'b1);
    bit loaded;
    modeBuf = m; capEnN = cen; dataIn = d; parIn = p; rstN = rst;
    #1;
    if (m) chk(outA == d, "R2", int'(outA), int'(d));
    else   chk(outA == expHold, "R3", int'(outA), int'(expHold));
    chk(outB == outA, "R5", int'(outB), int'(outA));
    @(posedge clk);
    loaded = !d[10];
    if (!rst) begin
      expHold = '0; expPrev = '0; expErr = 1'b0;
    end else begin
      if (!d[10]) expErr = ~((^expPrev) ^ p);
      expPrev = d;
      if (!cen) expHold = d;
      else      expHold[11:8] = d[11:8];
    end
    @(negedge clk);
    if (rst) begin
      if (loaded) chk(errOe == expErr, "R6", int'(errOe), int'(expErr));
      else        chk(errOe == expErr, "R7", int'(errOe), int'(expErr));
      if (!m) begin
        if (cen) chk(outA == expHold, "R4", int'(outA), int'(expHold));
        else     chk(outA == expHold, "R3", int'(outA), int'(expHold));
      end
    end
    chk(errVal == 1'b0, "R8", int'(errVal), 0);
    chk(errWire == ~expErr, "R8", int'(errWire), int'(~expErr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: reset clears everything
    step(1'b0, 1'b0, 12'hFFF, 1'b1, 1'b0);
    step(1'b0, 1'b0, 12'hBFF, 1'b0, 1'b0);
    chk(outA == 12'h000, "R1", int'(outA), 0);
    chk(errOe == 1'b0, "R1", int'(errOe), 0);

    // R3: full load in register mode
    step(1'b0, 1'b0, 12'hA5C, goodPar(expPrev));
    chk(outA == 12'hA5C, "R3", int'(outA), 32'hA5C);
    // R4: lower bits hold, upper bits load
    step(1'b0, 1'b1, 12'h3C3, goodPar(expPrev));
    chk(outA == 12'h35C, "R4", int'(outA), 32'h35C);
    // R2: buffer mode toggling
    step(1'b1, 1'b1, 12'h0F0, goodPar(expPrev));
    step(1'b0, 1'b1, 12'h1E1, goodPar(expPrev));
    step(1'b1, 1'b0, 12'h2D2, goodPar(expPrev));
    chk(outA == 12'h2D2 && outB == 12'h2D2, "R2", int'(outA), 32'h2D2);

    // R6: single-bit parity fault with the error register enabled
    step(1'b0, 1'b0, 12'h001, goodPar(expPrev));
    step(1'b0, 1'b0, 12'h003, ~goodPar(expPrev));
    chk(errOe == 1'b1, "R6", int'(errOe), 1);
    chk(errWire == 1'b0, "R8", int'(errWire), 0);
    // R7: bit 10 high keeps the flag despite good parity
    step(1'b0, 1'b0, 12'h400, goodPar(expPrev));
    step(1'b0, 1'b0, 12'h401, goodPar(expPrev));
    chk(errOe == 1'b1, "R7", int'(errOe), 1);
    step(1'b0, 1'b0, 12'h010, goodPar(expPrev));
    chk(errOe == 1'b0, "R6", int'(errOe), 0);

    // R9: checker sees the whole word in buffer mode with enable high
    step(1'b1, 1'b1, 12'h0FF, goodPar(expPrev));
    step(1'b1, 1'b1, 12'h022, ~goodPar(expPrev));
    chk(errOe == 1'b1, "R9", int'(errOe), 1);
    step(1'b1, 1'b1, 12'h000, goodPar(expPrev));
    chk(errOe == 1'b0, "R9", int'(errOe), 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] w;
      bit m, c, bad;
      w   = 12'($urandom);
      m   = 1'($urandom);
      c   = 1'($urandom);
      bad = ($urandom % 5) == 0;
      step(m, c, w, goodPar(expPrev) ^ bad);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule